// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block turns an asynchronous serial bit stream into parallel characters. A 16x bit-rate enable pulse (`tick16`) paces it. A falling level seen on a tick is taken as a possible start bit. The start bit is confirmed half a bit later, and every later bit is sampled once at its centre. The receiver accepts 5 to 8 data bits, an optional parity bit (odd, even or forced) and one or two stop bits. Each finished character goes into a holding buffer that the host reads at its own pace.

Status flags sit next to the buffer. The data-ready flag clears when the buffer is read. The overrun, parity, framing and break flags stay set until a status read. `errPending` summarises the error flags for the interrupt logic. A loopback select swaps the serial input pin for the local transmitter's output stream, which allows on-chip self-test. The host bus decoder and the baud divider sit outside this block.

Top module: `serial_rx_line`

## Requirements
- R1: `wordLen` selects the data bits per character (00=5, 01=6, 10=7, 11=8). The first data bit received lands in `rxBuf[0]`, and buffer bits above the word length read 0.
- R2: A low line on a tick starts a candidate start bit. It is confirmed on the 8th tick after that. If the line is high then, the receiver goes back to idle and no character is produced.
- R3: Each data, parity and stop bit is sampled 16 ticks after the previous sample. On the clock edge of the final stop sample the character enters `rxBuf` and `dataReady` is set. A `bufRead` pulse clears `dataReady`.
- R4: If a character is loaded while `dataReady` is still set and no `bufRead` comes in that cycle, `overrunErr` is set and the older character is replaced.
- R5: With `parityOn`=1 and `stickSel`=0, the parity bit must make the count of ones across data and parity even when `evenSel`=1, or odd when `evenSel`=0. A mismatch sets `parityErr`.
- R6: With `parityOn`=1 and `stickSel`=1, the expected parity bit is 1 when `evenSel`=0 and 0 when `evenSel`=1.
- R7: A stop bit sampled low sets `framingErr`. With `twoStop`=1 and a word length of 6 to 8 bits, both stop bits are checked. With 5 bits only one stop bit is checked.
- R8: When every sample of a character (start, data, parity and stops) is low, `breakSeen` is set together with `framingErr`, and a zero character is loaded with `dataReady`. After any low stop sample, no new start is accepted until the line is seen high on a tick.
- R9: The overrun, parity, framing and break flags are sticky. A clean character does not clear them. A `statusRead` pulse clears them, but a character completing in the same cycle sets its own errors.
- R10: With `loopSel`=1 the receiver takes `loopData` and ignores `serialIn`.
- R11: `errPending` is high exactly when at least one of overrun, parity, framing or break is set.
- R12: After reset the buffer is zero and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| serialIn | input | 1 | Serial line input, already synchronous to `clk` |
| loopSel | input | 1 | 1 selects `loopData` as the receive stream |
| loopData | input | 1 | Local transmitter output for loopback |
| wordLen | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parityOn | input | 1 | Parity bit present and checked |
| evenSel | input | 1 | Even parity select |
| stickSel | input | 1 | Forced parity value |
| twoStop | input | 1 | Check a second stop bit (6-8 bit words) |
| bufRead | input | 1 | Host read of the receive buffer |
| statusRead | input | 1 | Host read of the status flags |
| rxBuf | output | 8 | Last received character |
| dataReady | output | 1 | Unread character in buffer |
| overrunErr | output | 1 | Character lost to overwrite |
| parityErr | output | 1 | Parity mismatch seen |
| framingErr | output | 1 | Low stop bit seen |
| breakSeen | output | 1 | All-zero character seen |
| errPending | output | 1 | Any error flag set |

## Verification
A wrong bit counter or sampling phase shows up at the ports when the character ends. `rxBuf` and `dataReady` then change on a different clock from the one that follows the final stop sample. The buffer value also shifts, so a per-clock comparison flags the fault within one character time. Faults in the flag logic, such as a flag cleared by a clean character or a missing overrun, show on the next cycle as a mismatch against the reference model. A receiver stuck after a break or a glitch shows as a character that never arrives. The bench drives short pulses, breaks, every parity mode and loopback, and each of these states can be observed.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_MAX = 8;
  localparam int IDX_W = $clog2(DATA_MAX);

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP1, RX_STOP2, RX_HUNT
  } rxState_t;

  typedef struct packed {
    logic startClr;
    logic sampleData;
    logic sampleParity;
    logic sampleStop;
    logic commit;
    logic [IDX_W-1:0] bitIdx;
  } rxStrobes_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic lineIn,
  input  logic [1:0] wordLen,
  input  logic parityOn,
  input  logic twoStop,
  input  logic frameBad,
  output rxStrobes_t strobes
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);

  rxState_t state, stateNext;
  logic [CNT_W-1:0] tickCnt, tickCntNext;
  logic [IDX_W-1:0] bitIdx, bitIdxNext;
  logic [IDX_W-1:0] lastIdx;
  logic sampleNow;
  logic needTwo;

  assign lastIdx = IDX_W'(DATA_MAX - 4) + IDX_W'(wordLen);
  assign needTwo = twoStop && (wordLen != 2'b00);
  assign sampleNow = tick && ((state == RX_START) ? (tickCnt == MID_LAST)
                                                   : (tickCnt == FULL_LAST));

  always_comb begin
    stateNext = state;
    tickCntNext = tickCnt;
    bitIdxNext = bitIdx;
    strobes = '0;
    strobes.bitIdx = bitIdx;
    case (state)
      RX_IDLE: begin
        if (tick && !lineIn) begin
          stateNext = RX_START;
          tickCntNext = '0;
        end
      end
      RX_START: begin
        if (sampleNow) begin
          tickCntNext = '0;
          if (lineIn) begin
            stateNext = RX_IDLE;
          end else begin
            stateNext = RX_DATA;
            bitIdxNext = '0;
            strobes.startClr = 1'b1;
          end
        end else if (tick) begin
          tickCntNext = tickCnt + 1'b1;
        end
      end
      RX_DATA: begin
        if (sampleNow) begin
          tickCntNext = '0;
          strobes.sampleData = 1'b1;
          if (bitIdx == lastIdx) begin
            stateNext = parityOn ? RX_PARITY : RX_STOP1;
          end else begin
            bitIdxNext = bitIdx + 1'b1;
          end
        end else if (tick) begin
          tickCntNext = tickCnt + 1'b1;
        end
      end
      RX_PARITY: begin
        if (sampleNow) begin
          tickCntNext = '0;
          strobes.sampleParity = 1'b1;
          stateNext = RX_STOP1;
        end else if (tick) begin
          tickCntNext = tickCnt + 1'b1;
        end
      end
      RX_STOP1: begin
        if (sampleNow) begin
          tickCntNext = '0;
          strobes.sampleStop = 1'b1;
          if (needTwo) begin
            stateNext = RX_STOP2;
          end else begin
            strobes.commit = 1'b1;
            stateNext = frameBad ? RX_HUNT : RX_IDLE;
          end
        end else if (tick) begin
          tickCntNext = tickCnt + 1'b1;
        end
      end
      RX_STOP2: begin
        if (sampleNow) begin
          tickCntNext = '0;
          strobes.sampleStop = 1'b1;
          strobes.commit = 1'b1;
          stateNext = frameBad ? RX_HUNT : RX_IDLE;
        end else if (tick) begin
          tickCntNext = tickCnt + 1'b1;
        end
      end
      RX_HUNT: begin
        if (tick && lineIn) stateNext = RX_IDLE;
      end
      default: stateNext = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= RX_IDLE;
      tickCnt <= '0;
      bitIdx <= '0;
    end else begin
      state <= stateNext;
      tickCnt <= tickCntNext;
      bitIdx <= bitIdxNext;
    end
  end
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  rxStrobes_t strobes,
  input  logic evenSel,
  input  logic stickSel,
  input  logic bufRead,
  input  logic statusRead,
  output logic frameBad,
  output logic [DATA_MAX-1:0] rxBuf,
  output logic dataReady,
  output logic overrunErr,
  output logic parityErr,
  output logic framingErr,
  output logic breakSeen
);
  logic [DATA_MAX-1:0] shiftReg;
  logic parPend;
  logic framePend;
  logic allLow;
  logic expParity;
  logic breakNow;
  logic overNow;

  assign frameBad = framePend | ~lineIn;
  assign expParity = stickSel ? ~evenSel : (evenSel ? ^shiftReg : ~^shiftReg);
  assign breakNow = allLow & ~lineIn;
  assign overNow = dataReady & ~bufRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parPend <= 1'b0;
      framePend <= 1'b0;
      allLow <= 1'b0;
    end else begin
      if (strobes.startClr) begin
        shiftReg <= '0;
        parPend <= 1'b0;
        framePend <= 1'b0;
        allLow <= 1'b1;
      end
      if (strobes.sampleData) begin
        shiftReg[strobes.bitIdx] <= lineIn;
        allLow <= allLow & ~lineIn;
      end
      if (strobes.sampleParity) begin
        parPend <= (lineIn != expParity);
        allLow <= allLow & ~lineIn;
      end
      if (strobes.sampleStop) begin
        framePend <= framePend | ~lineIn;
        allLow <= allLow & ~lineIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0;
      dataReady <= 1'b0;
      overrunErr <= 1'b0;
      parityErr <= 1'b0;
      framingErr <= 1'b0;
      breakSeen <= 1'b0;
    end else if (strobes.commit) begin
      rxBuf <= shiftReg;
      dataReady <= 1'b1;
      overrunErr <= (overrunErr & ~statusRead) | overNow;
      parityErr <= (parityErr & ~statusRead) | parPend;
      framingErr <= (framingErr & ~statusRead) | frameBad;
      breakSeen <= (breakSeen & ~statusRead) | breakNow;
    end else begin
      if (bufRead) dataReady <= 1'b0;
      if (statusRead) begin
        overrunErr <= 1'b0;
        parityErr <= 1'b0;
        framingErr <= 1'b0;
        breakSeen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_rx_line.sv
module serial_rx_line
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick16,
  input  logic serialIn,
  input  logic loopSel,
  input  logic loopData,
  input  logic [1:0] wordLen,
  input  logic parityOn,
  input  logic evenSel,
  input  logic stickSel,
  input  logic twoStop,
  input  logic bufRead,
  input  logic statusRead,
  output logic [7:0] rxBuf,
  output logic dataReady,
  output logic overrunErr,
  output logic parityErr,
  output logic framingErr,
  output logic breakSeen,
  output logic errPending
);
  rxStrobes_t strobes;
  logic lineIn;
  logic frameBad;
  logic frameDone;

  assign lineIn = loopSel ? loopData : serialIn;
  assign frameDone = strobes.commit;
  assign errPending = overrunErr | parityErr | framingErr | breakSeen;

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick16), .lineIn(lineIn),
    .wordLen(wordLen), .parityOn(parityOn), .twoStop(twoStop),
    .frameBad(frameBad), .strobes(strobes)
  );

  serial_rx_datapath i_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strobes(strobes),
    .evenSel(evenSel), .stickSel(stickSel), .bufRead(bufRead),
    .statusRead(statusRead), .frameBad(frameBad), .rxBuf(rxBuf),
    .dataReady(dataReady), .overrunErr(overrunErr), .parityErr(parityErr),
    .framingErr(framingErr), .breakSeen(breakSeen)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic clk,
  input logic rstN,
  input logic frameDone,
  input logic bufRead,
  input logic statusRead,
  input logic [1:0] wordLen,
  input logic [7:0] rxBuf,
  input logic dataReady,
  input logic overrunErr,
  input logic framingErr,
  input logic breakSeen,
  input logic errPending
);
  assert_load_sets_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> dataReady);
  assert_read_clears_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bufRead && !frameDone) |=> !dataReady);
  assert_overrun_on_unread_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && dataReady && !bufRead) |=> overrunErr);
  assert_short_word_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && wordLen == 2'b00) |=> (rxBuf[7:5] == 3'b000));
  assert_break_with_framing_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakSeen) |-> framingErr);
  assert_status_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !frameDone) |=> !errPending);
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!statusRead && !frameDone) |=> $stable(errPending));
endmodule

bind serial_rx_line serial_rx_checker i_checker (
  .clk(clk), .rstN(rstN), .frameDone(frameDone), .bufRead(bufRead),
  .statusRead(statusRead), .wordLen(wordLen), .rxBuf(rxBuf),
  .dataReady(dataReady), .overrunErr(overrunErr), .framingErr(framingErr),
  .breakSeen(breakSeen), .errPending(errPending)
);

// File: tb/test_serial_rx_line.sv
module test_serial_rx_line;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic serialIn = 1'b1;
  logic loopSel = 1'b0;
  logic loopData = 1'b1;
  logic [1:0] wordLen = 2'b11;
  logic parityOn = 1'b0;
  logic evenSel = 1'b0;
  logic stickSel = 1'b0;
  logic twoStop = 1'b0;
  logic bufRead = 1'b0;
  logic statusRead = 1'b0;
  logic [7:0] rxBuf;
  logic dataReady, overrunErr, parityErr, framingErr, breakSeen, errPending;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  serial_rx_line i_serial_rx_line (
    .clk(clk), .rstN(rstN), .tick16(tick16), .serialIn(serialIn),
    .loopSel(loopSel), .loopData(loopData), .wordLen(wordLen),
    .parityOn(parityOn), .evenSel(evenSel), .stickSel(stickSel),
    .twoStop(twoStop), .bufRead(bufRead), .statusRead(statusRead),
    .rxBuf(rxBuf), .dataReady(dataReady), .overrunErr(overrunErr),
    .parityErr(parityErr), .framingErr(framingErr), .breakSeen(breakSeen),
    .errPending(errPending)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int tickDiv = 0;
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % TICK_DIV;
    tick16 <= (tickDiv == 0);
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: sample k of a character falls 8 + 16k ticks after detection.
  bit [7:0] mBuf;
  bit mDr, mOe, mPe, mFe, mBi;
  int mSt, tc;
  bit smp[$];
  bit ln, doCommit, peN, feN, biN, pb, expP;
  bit [7:0] dd;
  int nd, np, ns;

  always @(posedge clk) begin
    if (!rstN) begin
      mBuf = 0; mDr = 0; mOe = 0; mPe = 0; mFe = 0; mBi = 0; mSt = 0; tc = 0;
      smp.delete();
    end else begin
      ln = loopSel ? loopData : serialIn;
      doCommit = 0;
      nd = 5 + int'(wordLen);
      np = parityOn ? 1 : 0;
      ns = (twoStop && wordLen != 0) ? 2 : 1;
      if (tick16) begin
        if (mSt == 0) begin
          if (!ln) begin mSt = 1; tc = 0; smp.delete(); end
        end else if (mSt == 1) begin
          tc++;
          if (tc >= 8 && (tc - 8) % 16 == 0) begin
            smp.push_back(ln);
            if (smp.size() == 1 && ln) mSt = 0;
            else if (smp.size() == 1 + nd + np + ns) doCommit = 1;
          end
        end else begin
          if (ln) mSt = 0;
        end
      end
      if (doCommit) begin
        dd = 0;
        for (int i = 0; i < nd; i++) dd[i] = smp[1 + i];
        peN = 0;
        if (np == 1) begin
          pb = smp[1 + nd];
          expP = stickSel ? !evenSel : (evenSel ? ^dd : !(^dd));
          peN = (pb != expP);
        end
        feN = 0;
        for (int i = 0; i < ns; i++) if (!smp[1 + nd + np + i]) feN = 1;
        biN = 1;
        foreach (smp[i]) if (smp[i]) biN = 0;
        mSt = feN ? 2 : 0;
      end
      begin
        bit oeN;
        oeN = doCommit && mDr && !bufRead;
        if (statusRead) begin mOe = 0; mPe = 0; mFe = 0; mBi = 0; end
        if (bufRead) mDr = 0;
        if (doCommit) begin
          mBuf = dd; mDr = 1;
          mOe |= oeN; mPe |= peN; mFe |= feN; mBi |= biN;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1 buffer", rxBuf, mBuf);
      chk("R3 ready", {7'b0, dataReady}, {7'b0, mDr});
      chk("R4 overrun", {7'b0, overrunErr}, {7'b0, mOe});
      chk("R5 parity", {7'b0, parityErr}, {7'b0, mPe});
      chk("R7 framing", {7'b0, framingErr}, {7'b0, mFe});
      chk("R8 break", {7'b0, breakSeen}, {7'b0, mBi});
      chk("R11 pending", {7'b0, errPending}, {7'b0, (mOe | mPe | mFe | mBi)});
    end
  end

  task automatic holdBit(input bit v, input bit lp);
    if (lp) loopData = v; else serialIn = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int n, input bit usePar,
                           input bit pBit, input int nStop, input bit s1,
                           input bit s2, input bit lp);
    holdBit(1'b0, lp);
    for (int i = 0; i < n; i++) holdBit(d[i], lp);
    if (usePar) holdBit(pBit, lp);
    holdBit(s1, lp);
    if (nStop == 2) holdBit(s2, lp);
    holdBit(1'b1, lp);
    holdBit(1'b1, lp);
  endtask

  task automatic pulseBufRead();
    bufRead = 1'b1; @(negedge clk); bufRead = 1'b0; @(negedge clk);
  endtask

  task automatic pulseStatusRead();
    statusRead = 1'b1; @(negedge clk); statusRead = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 buffer", rxBuf, 8'h00);
    chk("R12 flags", {2'b0, dataReady, overrunErr, parityErr, framingErr, breakSeen, errPending}, 8'h00);
    holdBit(1'b1, 1'b0);

    // R1 R3: 8N1 character, bit 0 first
    sendFrame(8'hA5, 8, 0, 0, 1, 1, 1, 0);
    chk("R1 eight bits", rxBuf, 8'hA5);
    chk("R3 ready set", {7'b0, dataReady}, 8'h01);
    pulseBufRead();
    chk("R3 ready cleared", {7'b0, dataReady}, 8'h00);

    // R1: 5-bit word, upper bits zero
    wordLen = 2'b00;
    sendFrame(8'hF5, 5, 0, 0, 1, 1, 1, 0);
    chk("R1 five bits", rxBuf, 8'h15);
    pulseBufRead();

    // R5: even parity, 7 bits
    wordLen = 2'b10; parityOn = 1; evenSel = 1;
    sendFrame(8'h35, 7, 1, 0, 1, 1, 1, 0);
    chk("R5 even good", {7'b0, parityErr}, 8'h00);
    sendFrame(8'h35, 7, 1, 1, 1, 1, 1, 0);
    chk("R5 even bad", {7'b0, parityErr}, 8'h01);
    chk("R4 overrun after unread", {7'b0, overrunErr}, 8'h01);
    // R9: a clean character leaves the flags set
    pulseBufRead();
    sendFrame(8'h35, 7, 1, 0, 1, 1, 1, 0);
    chk("R9 sticky parity", {7'b0, parityErr}, 8'h01);
    chk("R11 pending high", {7'b0, errPending}, 8'h01);
    pulseStatusRead();
    chk("R9 cleared by status read", {7'b0, errPending}, 8'h00);
    pulseBufRead();

    // R5: odd parity
    evenSel = 0;
    sendFrame(8'h35, 7, 1, 1, 1, 1, 1, 0);
    chk("R5 odd good", {7'b0, parityErr}, 8'h00);
    pulseBufRead();

    // R6: stick parity
    stickSel = 1; evenSel = 0; wordLen = 2'b11;
    sendFrame(8'h81, 8, 1, 1, 1, 1, 1, 0);
    chk("R6 stick one ok", {7'b0, parityErr}, 8'h00);
    pulseBufRead();
    evenSel = 1;
    sendFrame(8'h81, 8, 1, 1, 1, 1, 1, 0);
    chk("R6 stick zero expected", {7'b0, parityErr}, 8'h01);
    pulseBufRead(); pulseStatusRead();
    stickSel = 0; parityOn = 0; evenSel = 0;

    // R7: framing error, single and second stop bit
    sendFrame(8'h5A, 8, 0, 0, 1, 0, 1, 0);
    chk("R7 low stop", {7'b0, framingErr}, 8'h01);
    pulseBufRead(); pulseStatusRead();
    twoStop = 1;
    sendFrame(8'h5A, 8, 0, 0, 2, 1, 0, 0);
    chk("R7 low second stop", {7'b0, framingErr}, 8'h01);
    chk("R1 data with bad stop", rxBuf, 8'h5A);
    pulseBufRead(); pulseStatusRead();
    wordLen = 2'b00;
    sendFrame(8'h0C, 5, 0, 0, 1, 1, 1, 0);
    chk("R7 five bits one stop", {7'b0, framingErr}, 8'h00);
    pulseBufRead();
    twoStop = 0; wordLen = 2'b11;

    // R4: overrun, newer character kept
    sendFrame(8'h11, 8, 0, 0, 1, 1, 1, 0);
    sendFrame(8'h22, 8, 0, 0, 1, 1, 1, 0);
    chk("R4 overrun", {7'b0, overrunErr}, 8'h01);
    chk("R4 newer kept", rxBuf, 8'h22);
    pulseBufRead(); pulseStatusRead();

    // R8: break, then hunt for mark
    serialIn = 0;
    repeat (2 * 10 * BIT_CLKS) @(negedge clk);
    serialIn = 1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    chk("R8 break", {7'b0, breakSeen}, 8'h01);
    chk("R8 framing with break", {7'b0, framingErr}, 8'h01);
    chk("R8 zero char", rxBuf, 8'h00);
    chk("R8 ready", {7'b0, dataReady}, 8'h01);
    pulseBufRead(); pulseStatusRead();
    sendFrame(8'hC3, 8, 0, 0, 1, 1, 1, 0);
    chk("R8 recovers", rxBuf, 8'hC3);
    pulseBufRead();

    // R2: short low pulse rejected
    serialIn = 0;
    repeat (3 * TICK_DIV) @(negedge clk);
    serialIn = 1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R2 glitch ignored", {7'b0, dataReady}, 8'h00);

    // R10: loopback, pin held low
    loopSel = 1; serialIn = 0;
    sendFrame(8'h6E, 8, 0, 0, 1, 1, 1, 1);
    chk("R10 loopback data", rxBuf, 8'h6E);
    chk("R10 pin ignored", {7'b0, framingErr}, 8'h00);
    pulseBufRead();
    serialIn = 1;
    holdBit(1'b1, 1'b0);
    loopSel = 0;
    holdBit(1'b1, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule